// File: doc/BRIEF.md
# Boundary-Scan Cell Chain with Pin Modes

This block is a chain of boundary-scan cells that sits between a chip's core and its pads. There is one cell for each of N input pins. Each of M output pins has two cells: one for its data and one for its driver enable. Every cell holds a shift flop, clocked on the rising test-clock edge, and an update latch, loaded on the falling edge. A separate test access port controller supplies capture, shift and update strobes and a 3-bit mode code. The chain has its own serial input and serial output.

The mode code decides what reaches the core and the pads:
- System signals can pass straight through.
- The pads can be held at values loaded into the chain beforehand.
- Every driver can be turned off.
- Every driver can be turned off while its data still comes from the scan cell.
- The core can be driven from the chain in internal test.

Pad drivers are not part of this block. Pad data and pad enables leave it as ordinary outputs.

Top module: `bscan_chain`

## Requirements
- R1: After reset, every shift flop and every update latch holds 0. In clamp mode this shows as pad data 0 and pad enables 0. In internal-test mode it shows as core inputs 0.
- R2: The chain runs from `scan_in` through the input cells (pin 0 first), then the output data cells, then the output enable cells, to `scan_out`. `scan_out` is the shift flop of the last enable cell. Each rising `tck` with `shift_en` high moves the chain one place toward `scan_out`.
- R3: In sample mode (code 1), a rising edge with `capture_en` high loads the following values:
  - each input cell gets its `pin_in` bit;
  - each data cell gets `core_out`;
  - each enable cell gets `core_oe`.
- R4: In internal-test mode (code 5), capture loads each input cell with the inverse of the value that cell is currently feeding to the core. Data cells get the true `core_out` and enable cells get the true `core_oe`.
- R5: On a falling `tck` with `update_en` high, in sample or internal-test mode, every update latch copies its shift flop.
- R6: Mode codes are 0 normal, 1 sample, 2 clamp, 3 high-impedance, 4 clamp-disabled and 5 internal test. Codes 6 and 7 act as normal. In normal and sample modes, `core_in`=`pin_in`, `pad_out`=`core_out` and `pad_oe`=`core_oe`.
- R7: In clamp mode, `pad_out` and `pad_oe` come from the update latches of the data and enable cells, and `core_in`=`pin_in`.
- R8: In high-impedance mode, every `pad_oe` bit is 0, `pad_out`=`core_out` and `core_in`=`pin_in`.
- R9: In clamp-disabled mode, every `pad_oe` bit is 0 and `pad_out` comes from the data-cell update latches.
- R10: In internal-test mode, `core_in` comes from the input-cell update latches, and the pads come from the data and enable latches.
- R11: In modes 0, 2, 3, 4, 6 and 7, the capture, shift and update strobes have no effect on any shift flop or update latch.
- R12: When `capture_en` and `shift_en` are both high, capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode | input | 3 | Pin mode code |
| capture_en | input | 1 | Capture strobe (rising edge) |
| shift_en | input | 1 | Shift strobe (rising edge) |
| update_en | input | 1 | Update strobe (falling edge) |
| scan_in | input | 1 | Serial chain input |
| scan_out | output | 1 | Serial chain output |
| pin_in | input | N_IN | Values arriving from input pads |
| core_in | output | N_IN | Values presented to the core |
| core_out | input | N_OUT | Core output data |
| core_oe | input | N_OUT | Core output enables |
| pad_out | output | N_OUT | Data to output pad drivers |
| pad_oe | output | N_OUT | Enables to output pad drivers |

## Verification
The hardest case to reach is the inverted internal-test capture. It only shows a difference when the input latches already hold a known, non-trivial pattern. The stimulus first shifts a pattern in under sample mode and updates it. It then switches to internal test, captures, and shifts the result out so the inverted bits appear on `scan_out`. A second hard case is strobes that must be ignored. These are fired in the clamp, high-impedance and normal modes, and the chain contents are then shifted out in sample mode to show that nothing moved.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [2:0] {
    BS_NORMAL = 3'd0,
    BS_SAMPLE = 3'd1,
    BS_CLAMP  = 3'd2,
    BS_HIGHZ  = 3'd3,
    BS_CLAMPZ = 3'd4,
    BS_INTEST = 3'd5
  } bs_mode_e;

  function automatic logic chain_live(input logic [2:0] m);
    return (m == BS_SAMPLE) || (m == BS_INTEST);
  endfunction
endpackage

// File: rtl/bscan_rst_sync.sv
module bscan_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_n = stage_q[1];
endmodule

// File: rtl/bscan_cell.sv
module bscan_cell (
  input  logic tck,
  input  logic rst_n,
  input  logic cap_en,
  input  logic sh_en,
  input  logic upd_en,
  input  logic cap_d,
  input  logic si,
  output logic sq,
  output logic uq
);
  logic sq_nx;
  logic uq_nx;

  // capture has priority over shift
  always_comb begin
    sq_nx = sq;
    if (cap_en)     sq_nx = cap_d;
    else if (sh_en) sq_nx = si;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) sq <= 1'b0;
    else        sq <= sq_nx;
  end

  always_comb uq_nx = upd_en ? sq : uq;

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) uq <= 1'b0;
    else        uq <= uq_nx;
  end
endmodule

// File: rtl/bscan_pinmux.sv
module bscan_pinmux
  import bscan_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3,
  localparam int L    = N_IN + 2 * N_OUT
) (
  input  logic [2:0]       mode,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  input  logic [N_IN-1:0]  upd_in,
  input  logic [N_OUT-1:0] upd_dat,
  input  logic [N_OUT-1:0] upd_oe,
  output logic [N_IN-1:0]  core_in,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_OUT-1:0] pad_oe,
  output logic [L-1:0]     cap_d
);
  logic [N_IN-1:0] in_cap;

  always_comb begin
    in_cap = (mode == BS_INTEST) ? ~upd_in : pin_in;
    cap_d  = {core_oe, core_out, in_cap};
  end

  always_comb begin
    core_in = pin_in;
    pad_out = core_out;
    pad_oe  = core_oe;
    case (mode)
      BS_CLAMP: begin
        pad_out = upd_dat;
        pad_oe  = upd_oe;
      end
      BS_HIGHZ: begin
        pad_oe = '0;
      end
      BS_CLAMPZ: begin
        pad_out = upd_dat;
        pad_oe  = '0;
      end
      BS_INTEST: begin
        core_in = upd_in;
        pad_out = upd_dat;
        pad_oe  = upd_oe;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic [2:0]       mode,
  input  logic             capture_en,
  input  logic             shift_en,
  input  logic             update_en,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_OUT-1:0] pad_oe
);
  localparam int L      = N_IN + 2 * N_OUT;
  localparam int DAT_LO = N_IN;
  localparam int OE_LO  = N_IN + N_OUT;

  logic         rst_n;
  logic         live;
  logic         cap_g, sh_g, upd_g;
  logic [L-1:0] sq_vec, uq_vec, cap_vec, si_vec;

  bscan_rst_sync u_rst (.clk(tck), .arst_n(trst_n), .rst_n(rst_n));

  always_comb begin
    live  = chain_live(mode);
    cap_g = live & capture_en;
    sh_g  = live & shift_en;
    upd_g = live & update_en;
  end

  for (genvar k = 0; k < L; k++) begin : g_cell
    if (k == 0) begin : g_head
      assign si_vec[k] = scan_in;
    end else begin : g_link
      assign si_vec[k] = sq_vec[k-1];
    end
    bscan_cell u_cell (
      .tck   (tck),
      .rst_n (rst_n),
      .cap_en(cap_g),
      .sh_en (sh_g),
      .upd_en(upd_g),
      .cap_d (cap_vec[k]),
      .si    (si_vec[k]),
      .sq    (sq_vec[k]),
      .uq    (uq_vec[k])
    );
  end

  assign scan_out = sq_vec[L-1];

  bscan_pinmux #(.N_IN(N_IN), .N_OUT(N_OUT)) u_mux (
    .mode    (mode),
    .pin_in  (pin_in),
    .core_out(core_out),
    .core_oe (core_oe),
    .upd_in  (uq_vec[N_IN-1:0]),
    .upd_dat (uq_vec[OE_LO-1:DAT_LO]),
    .upd_oe  (uq_vec[L-1:OE_LO]),
    .core_in (core_in),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .cap_d   (cap_vec)
  );

  // R11: strobes outside sample/internal test leave the shift stage alone
  a_r11_hold_when_idle: assert property (@(posedge tck) disable iff (!rst_n)
    !live |=> $stable(sq_vec));

  // R2: one place per shift toward scan_out
  a_r2_shift_step: assert property (@(posedge tck) disable iff (!rst_n)
    (live && shift_en && !capture_en) |=>
      sq_vec == {$past(sq_vec[L-2:0]), $past(scan_in)});

  // R12: capture wins over shift
  a_r12_capture_wins: assert property (@(posedge tck) disable iff (!rst_n)
    (live && capture_en && shift_en) |=>
      sq_vec[OE_LO-1:DAT_LO] == $past(core_out));

  // R8, R9: drivers disabled in the two off modes
  a_r8_drivers_off: assert property (@(posedge tck) disable iff (!rst_n)
    (mode == BS_HIGHZ || mode == BS_CLAMPZ) |-> pad_oe == '0);

  // R9: disabled drivers still see cell data
  a_r9_clampz_data: assert property (@(posedge tck) disable iff (!rst_n)
    (mode == BS_CLAMPZ) |-> pad_out == uq_vec[OE_LO-1:DAT_LO]);

  // R10: core fed from input latches in internal test
  a_r10_intest_core: assert property (@(posedge tck) disable iff (!rst_n)
    (mode == BS_INTEST) |-> core_in == uq_vec[N_IN-1:0]);
endmodule

// File: tb/sim_bscan_chain.sv
module sim_bscan_chain;
  localparam int N_IN  = 4;
  localparam int N_OUT = 3;
  localparam int L     = N_IN + 2 * N_OUT;

  logic             tck = 1'b0;
  logic             trst_n;
  logic [2:0]       mode;
  logic             capture_en, shift_en, update_en, scan_in;
  logic             scan_out;
  logic [N_IN-1:0]  pin_in, core_in;
  logic [N_OUT-1:0] core_out, core_oe, pad_out, pad_oe;

  int total = 0;
  int bad   = 0;

  bit chq[$];
  bit upq[L];

  always #5 tck = ~tck;

  bscan_chain #(.N_IN(N_IN), .N_OUT(N_OUT)) u0 (
    .tck(tck), .trst_n(trst_n), .mode(mode),
    .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
    .scan_in(scan_in), .scan_out(scan_out),
    .pin_in(pin_in), .core_in(core_in),
    .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic bit live_m(input logic [2:0] m);
    return (m == 3'd1) || (m == 3'd5);
  endfunction

  task automatic check_one(input string tag, input string what,
                           input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [N_IN-1:0]  e_ci;
    logic [N_OUT-1:0] e_po, e_oe;
    for (int i = 0; i < N_IN; i++)
      e_ci[i] = (mode == 3'd5) ? upq[i] : pin_in[i];
    for (int j = 0; j < N_OUT; j++) begin
      e_po[j] = (mode == 3'd2 || mode == 3'd4 || mode == 3'd5) ? upq[N_IN+j] : core_out[j];
      if (mode == 3'd3 || mode == 3'd4)      e_oe[j] = 1'b0;
      else if (mode == 3'd2 || mode == 3'd5) e_oe[j] = upq[N_IN+N_OUT+j];
      else                                   e_oe[j] = core_oe[j];
    end
    check_one(tag, "scan_out", 8'(scan_out), 8'(chq[L-1]));
    check_one(tag, "core_in",  8'(core_in),  8'(e_ci));
    check_one(tag, "pad_out",  8'(pad_out),  8'(e_po));
    check_one(tag, "pad_oe",   8'(pad_oe),   8'(e_oe));
  endtask

  task automatic step(input logic [2:0] m, input bit c, input bit s,
                      input bit u, input bit si, input string tag);
    bit nv[L];
    mode = m; capture_en = c; shift_en = s; update_en = u; scan_in = si;
    @(negedge tck);
    if (live_m(m) && u)
      for (int k = 0; k < L; k++) upq[k] = chq[k];
    @(posedge tck);
    #1;
    if (live_m(m) && c) begin
      for (int i = 0; i < N_IN; i++)
        nv[i] = (m == 3'd5) ? ~upq[i] : pin_in[i];
      for (int j = 0; j < N_OUT; j++) begin
        nv[N_IN+j]       = core_out[j];
        nv[N_IN+N_OUT+j] = core_oe[j];
      end
      for (int k = 0; k < L; k++) chq[k] = nv[k];
    end else if (live_m(m) && s) begin
      chq.push_front(si);
      void'(chq.pop_back());
    end
    compare(tag);
  endtask

  task automatic shift_word(input logic [2:0] m, input logic [L-1:0] w, input string tag);
    for (int k = 0; k < L; k++) step(m, 0, 1, 0, w[k], tag);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < L; k++) begin chq.push_back(1'b0); upq[k] = 1'b0; end
    trst_n = 1'b0; mode = 3'd0; capture_en = 0; shift_en = 0; update_en = 0;
    scan_in = 0; pin_in = 4'b0110; core_out = 3'b101; core_oe = 3'b011;
    repeat (3) @(posedge tck);
    #1 trst_n = 1'b1;
    repeat (3) step(3'd0, 0, 0, 0, 0, "R1");
    step(3'd2, 0, 0, 0, 0, "R1");   // clamp: zero latches on pads
    step(3'd5, 0, 0, 0, 0, "R1");   // intest: zero latches to core
    shift_word(3'd1, 10'b0, "R1");  // shift flops read back as zero

    // R3 sample capture, then R2 shift-out with a new pattern in
    pin_in = 4'b1011; core_out = 3'b110; core_oe = 3'b011;
    step(3'd1, 1, 0, 0, 0, "R3");
    shift_word(3'd1, 10'b1100101101, "R2");
    step(3'd1, 0, 0, 1, 0, "R5");

    // pin modes against the updated latches
    core_out = 3'b001; core_oe = 3'b100; pin_in = 4'b0101;
    step(3'd2, 0, 0, 0, 0, "R7");
    step(3'd3, 0, 0, 0, 0, "R8");
    step(3'd4, 0, 0, 0, 0, "R9");
    core_out = 3'b010;
    step(3'd4, 0, 0, 0, 0, "R9");
    step(3'd0, 0, 0, 0, 0, "R6");
    step(3'd6, 0, 0, 0, 0, "R6");
    step(3'd7, 0, 0, 0, 0, "R6");

    // R11 strobes with no effect
    step(3'd2, 1, 1, 1, 1, "R11");
    step(3'd3, 1, 0, 1, 1, "R11");
    step(3'd4, 0, 1, 1, 1, "R11");
    step(3'd0, 1, 1, 1, 0, "R11");
    step(3'd7, 0, 1, 1, 1, "R11");
    step(3'd2, 0, 0, 0, 0, "R11");
    shift_word(3'd1, 10'b0110100110, "R11");
    step(3'd1, 0, 0, 1, 0, "R5");

    // R4 inverted capture in internal test, R10 drive from latches
    pin_in = 4'b1111; core_out = 3'b011; core_oe = 3'b110;
    step(3'd5, 0, 0, 0, 0, "R10");
    step(3'd5, 1, 0, 0, 0, "R4");
    shift_word(3'd5, 10'b1010010011, "R4");
    step(3'd5, 0, 0, 1, 0, "R10");
    pin_in = 4'b0000;
    step(3'd5, 0, 0, 0, 0, "R10");
    step(3'd5, 1, 0, 0, 0, "R4");
    shift_word(3'd5, 10'b0, "R4");

    // R12 capture beats shift
    core_out = 3'b100; core_oe = 3'b001; pin_in = 4'b1001;
    step(3'd1, 1, 1, 0, 1, "R12");
    shift_word(3'd1, 10'b1, "R12");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule